// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor request port and a slower main memory. Each request carries a 15-bit word address and, for stores, a 12-bit data word. The address is split into a 6-bit tag and a 9-bit set index. The index picks one of 512 sets. Each set holds two single-word lines. Each line keeps a tag, a data word, a valid flag and a modified flag. Each way in a set also has a recency flag. A request is accepted when `cpu_req` is high in the idle state. The requester holds the request until `cpu_ready` pulses, and then returns it low.

The controller is a five-state machine.
- **S_IDLE** accepts and latches a request (transition *accept*: S_IDLE→S_LOOKUP).
- **S_LOOKUP** compares both stored tags with the request tag.
  - On a hit it answers in the same cycle (*hit*: S_LOOKUP→S_IDLE).
  - On a miss it picks a victim way. It goes to **S_WRITEBACK** if the victim holds modified data (*dirty miss*). Otherwise it goes straight to **S_REFILL** (*clean miss*).
- S_WRITEBACK stores the victim word at the victim's own address and waits for the memory acknowledge (*flushed*: S_WRITEBACK→S_REFILL).
- S_REFILL reads the requested word. On acknowledge it installs the word, merging store data for a write (*filled*: S_REFILL→S_RESPOND).
- **S_RESPOND** presents the installed word with `cpu_ready` (*done*: S_RESPOND→S_IDLE).

Replacement keeps one recency flag per way. A flag of 1 marks that way as the eviction candidate.

Top module: `cache2w_top`

## Requirements
- R1: The tag is address bits [14:9] and the index is bits [8:0]. A request whose tag matches a valid line in either way of the indexed set is a hit. On a hit, `cpu_ready` is high in the cycle after the request is accepted, and `cpu_rdata` carries that line's word.
- R2: After reset, every line is invalid and both recency flags of every set are 1. `cpu_ready`, `mem_rd` and `mem_wr` are low.
- R3: A hit on way w sets the other way's recency flag to 1 and clears way w's flag to 0.
- R4: On a miss, the way whose recency flag is 1 is evicted. When both flags are 1, way 0 is evicted.
- R5: When a way is filled after a miss, its recency flag becomes 0 and the other way's flag becomes 1.
- R6: A valid, modified victim is written to memory before the refill read. The write goes to address {victim tag, index} with the victim's word. `mem_wr`, `mem_addr` and `mem_wdata` stay steady until `mem_ack`.
- R7: A victim that is invalid or unmodified causes no memory write.
- R8: A store that hits updates only the cached word and marks it modified. No memory access is made.
- R9: A store that misses first reads the word from memory. The store data then replaces the fetched word in the line, which is marked modified.
- R10: A refill reads memory at the request address. After `mem_ack`, the installed word is returned with `cpu_ready` one cycle later.
- R11: `mem_rd` and `mem_wr` are never high together. `cpu_ready` is never high while either memory request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 15 | Word address |
| cpu_wdata | input | 12 | Store data |
| cpu_rdata | output | 12 | Load data, valid while `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory completion, one cycle |

## Verification
A store that misses puts two writes to the same line into one cycle. The memory word arrives with `mem_ack`, and the processor's store data must be merged into the same line at that edge. The bench provokes this by storing to an address that is not cached and then loading it back. The load must return the store data, not the memory word. A later forced eviction must write that store data back to memory. A store hit also updates the line's word and both recency flags in the same cycle; the bench judges this through the eviction order that follows.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_WRITEBACK,
        S_REFILL,
        S_RESPOND
    } cache_state_t;

    localparam int NUM_WAYS = 2;

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int IDX_W  = 9,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_dirty,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dirty |-> rd_valid); // R7

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_use,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] use_q [2];

    generate
        for (genvar w = 0; w < 2; w++) begin : g_use
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    use_q[w] <= '1;
                end else if (upd_en) begin
                    use_q[w][upd_idx] <= (upd_way != w[0]);
                end
            end
            assign rd_use[w] = use_q[w][rd_idx];
        end
    endgenerate

    AST_USE_NEVER_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_use != 2'b00); // R5

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 12,
    parameter int IDX_W  = 9,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [IDX_W-1:0]  req_idx,
    output logic [TAG_W-1:0]  req_tag,
    input  logic [1:0]        way_hit,
    input  logic [TAG_W-1:0]  way_tag   [2],
    input  logic [DATA_W-1:0] way_data  [2],
    input  logic [1:0]        way_valid,
    input  logic [1:0]        way_dirty,
    input  logic [1:0]        set_use,
    output logic [1:0]        wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_dirty,
    output logic              lru_upd,
    output logic              lru_way
);
    cache_state_t      state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              victim_q;
    logic              victim_d;
    logic              hit_way;

    assign req_idx  = addr_q[IDX_W-1:0];
    assign req_tag  = addr_q[ADDR_W-1:IDX_W];
    assign victim_d = set_use[0] ? 1'b0 : 1'b1;
    assign hit_way  = way_hit[1];

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            victim_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && cpu_req) begin
                we_q    <= cpu_we;
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
            if (state_q == S_LOOKUP && way_hit == 2'b00) begin
                victim_q <= victim_d;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        wr_en     = 2'b00;
        wr_tag    = req_tag;
        wr_data   = wdata_q;
        wr_dirty  = 1'b0;
        lru_upd   = 1'b0;
        lru_way   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cpu_req) state_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                if (way_hit != 2'b00) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = way_data[hit_way];
                    lru_upd   = 1'b1;
                    lru_way   = hit_way;
                    if (we_q) begin
                        wr_en[hit_way] = 1'b1;
                        wr_data        = wdata_q;
                        wr_dirty       = 1'b1;
                    end
                    state_d = S_IDLE;
                end else if (way_valid[victim_d] && way_dirty[victim_d]) begin
                    state_d = S_WRITEBACK;
                end else begin
                    state_d = S_REFILL;
                end
            end
            S_WRITEBACK: begin
                mem_wr    = 1'b1;
                mem_addr  = {way_tag[victim_q], req_idx};
                mem_wdata = way_data[victim_q];
                if (mem_ack) state_d = S_REFILL;
            end
            S_REFILL: begin
                mem_rd   = 1'b1;
                mem_addr = addr_q;
                if (mem_ack) begin
                    wr_en[victim_q] = 1'b1;
                    wr_data         = we_q ? wdata_q : mem_rdata;
                    wr_dirty        = we_q;
                    lru_upd         = 1'b1;
                    lru_way         = victim_q;
                    state_d         = S_RESPOND;
                end
            end
            S_RESPOND: begin
                cpu_ready = 1'b1;
                cpu_rdata = way_data[victim_q];
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11
    AST_READY_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !(mem_rd || mem_wr)); // R11
    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R6
    AST_WB_THEN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr) |-> mem_rd); // R6
    AST_RESPOND_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESPOND) |-> ($past(state_q) == S_REFILL)); // R10

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 12,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  way_tag  [2];
    logic [DATA_W-1:0] way_data [2];
    logic [1:0]        way_valid;
    logic [1:0]        way_dirty;
    logic [1:0]        way_hit;
    logic [1:0]        set_use;
    logic [1:0]        wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              wr_dirty;
    logic              lru_upd;
    logic              lru_way;

    generate
        for (genvar w = 0; w < cache2w_pkg::NUM_WAYS; w++) begin : g_way
            cache2w_way #(
                .IDX_W (IDX_W),
                .TAG_W (TAG_W),
                .DATA_W(DATA_W)
            ) u_way (
                .clk     (clk),
                .rst_n   (rst_n),
                .rd_idx  (req_idx),
                .rd_tag  (way_tag[w]),
                .rd_data (way_data[w]),
                .rd_valid(way_valid[w]),
                .rd_dirty(way_dirty[w]),
                .wr_en   (wr_en[w]),
                .wr_idx  (req_idx),
                .wr_tag  (wr_tag),
                .wr_data (wr_data),
                .wr_dirty(wr_dirty)
            );
            assign way_hit[w] = way_valid[w] && (way_tag[w] == req_tag);
        end
    endgenerate

    cache2w_lru #(.IDX_W(IDX_W)) u_lru (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_use (set_use),
        .upd_en (lru_upd),
        .upd_idx(req_idx),
        .upd_way(lru_way)
    );

    cache2w_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_ack  (mem_ack),
        .req_idx  (req_idx),
        .req_tag  (req_tag),
        .way_hit  (way_hit),
        .way_tag  (way_tag),
        .way_data (way_data),
        .way_valid(way_valid),
        .way_dirty(way_dirty),
        .set_use  (set_use),
        .wr_en    (wr_en),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .wr_dirty (wr_dirty),
        .lru_upd  (lru_upd),
        .lru_way  (lru_way)
    );

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit)); // R1

endmodule

// File: tb/sim_cache2w_top.sv
module sim_cache2w_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [11:0] cpu_wdata = '0;
    logic [11:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_rd;
    logic        mem_wr;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int wb_cnt = 0;
    int rd_cnt = 0;
    logic [14:0] wb_addr_seen = '0;
    logic [11:0] wb_data_seen = '0;
    logic [11:0] mem_store [int];

    always #10 clk = ~clk; // 50 MHz

    cache2w_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [11:0] pattern(input logic [14:0] a);
        return ~a[11:0];
    endfunction

    // memory responder: acknowledge on the second cycle of a request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                cnt = 0;
            end else if (mem_rd || mem_wr) begin
                cnt++;
                if (cnt == 2) begin
                    if (mem_wr) begin
                        mem_store[int'(mem_addr)] = mem_wdata;
                        wb_cnt++;
                        wb_addr_seen = mem_addr;
                        wb_data_seen = mem_wdata;
                    end else begin
                        rd_cnt++;
                        mem_rdata = mem_store.exists(int'(mem_addr)) ?
                                    mem_store[int'(mem_addr)] : pattern(mem_addr);
                    end
                    mem_ack = 1'b1;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [14:0] a, input logic [11:0] wd,
                          output logic [11:0] rdata, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 200);
        rdata = cpu_rdata;
        cpu_req = 1'b0;
        if (lat >= 200) check(1'b0, "R10 timeout", lat, 0);
    endtask

    typedef struct packed {
        logic        we;
        logic [14:0] addr;
        logic [11:0] wdata;
        logic [11:0] exp_data;
        logic        exp_hit;
        logic        exp_wb;
        logic [14:0] wb_addr;
        logic [11:0] wb_data;
    } vec_t;

    // set 5 throughout, tags 1..4; memory word = ~addr[11:0] unless written
    localparam vec_t VEC [15] = '{
        '{1'b0, 15'h205, 12'h000, 12'hDFA, 1'b0, 1'b0, 15'h000, 12'h000}, // R4 tie -> way0
        '{1'b0, 15'h205, 12'h000, 12'hDFA, 1'b1, 1'b0, 15'h000, 12'h000}, // R1 hit
        '{1'b0, 15'h405, 12'h000, 12'hBFA, 1'b0, 1'b0, 15'h000, 12'h000}, // R5 -> way1
        '{1'b0, 15'h205, 12'h000, 12'hDFA, 1'b1, 1'b0, 15'h000, 12'h000}, // R3 hit way0
        '{1'b1, 15'h605, 12'h123, 12'h000, 1'b0, 1'b0, 15'h000, 12'h000}, // R9 write miss
        '{1'b0, 15'h605, 12'h000, 12'h123, 1'b1, 1'b0, 15'h000, 12'h000}, // R9 merge wins
        '{1'b0, 15'h805, 12'h000, 12'h7FA, 1'b0, 1'b0, 15'h000, 12'h000}, // R7 clean victim
        '{1'b0, 15'h405, 12'h000, 12'hBFA, 1'b0, 1'b1, 15'h605, 12'h123}, // R6 dirty victim
        '{1'b0, 15'h605, 12'h000, 12'h123, 1'b0, 1'b0, 15'h000, 12'h000}, // R10 refetch
        '{1'b1, 15'h405, 12'h456, 12'h000, 1'b1, 1'b0, 15'h000, 12'h000}, // R8 write hit
        '{1'b1, 15'h205, 12'h0AB, 12'h000, 1'b0, 1'b0, 15'h000, 12'h000}, // R4 evict way0
        '{1'b0, 15'h805, 12'h000, 12'h7FA, 1'b0, 1'b1, 15'h405, 12'h456}, // R8 dirty flushed
        '{1'b0, 15'h405, 12'h000, 12'h456, 1'b0, 1'b1, 15'h205, 12'h0AB}, // R6 R10
        '{1'b0, 15'h006, 12'h000, 12'hFF9, 1'b0, 1'b0, 15'h000, 12'h000}, // R1 other set
        '{1'b0, 15'h805, 12'h000, 12'h7FA, 1'b1, 1'b0, 15'h000, 12'h000}  // R3 R5 kept
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] rd;
        int lat;
        int wb0;
        int rd0;
        repeat (3) @(negedge clk);
        // R2: reset outputs
        check(cpu_ready == 1'b0, "R2 ready", cpu_ready, 0);
        check(mem_rd == 1'b0 && mem_wr == 1'b0, "R2 mem idle", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            wb0 = wb_cnt;
            rd0 = rd_cnt;
            access(VEC[i].we, VEC[i].addr, VEC[i].wdata, rd, lat);
            if (!VEC[i].we)
                check(rd == VEC[i].exp_data, "R1/R10 data", rd, VEC[i].exp_data);
            if (VEC[i].exp_hit) begin
                check(lat == 1, "R1/R3 hit latency", lat, 1);
                check(rd_cnt == rd0 && wb_cnt == wb0, "R8 no memory on hit",
                      rd_cnt - rd0 + wb_cnt - wb0, 0);
            end else begin
                check(lat > 1, "R4/R5 miss expected", lat, 2);
                check(rd_cnt == rd0 + 1, "R10 one refill read", rd_cnt - rd0, 1);
            end
            if (VEC[i].exp_wb) begin
                check(wb_cnt == wb0 + 1, "R6 write-back count", wb_cnt - wb0, 1);
                check(wb_addr_seen == VEC[i].wb_addr, "R6 write-back address",
                      wb_addr_seen, VEC[i].wb_addr);
                check(wb_data_seen == VEC[i].wb_data, "R6 write-back data",
                      wb_data_seen, VEC[i].wb_data);
            end else begin
                check(wb_cnt == wb0, "R7 no write-back", wb_cnt - wb0, 0);
            end
        end

        // R2: reset invalidates everything mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(cpu_ready == 1'b0 && mem_rd == 1'b0 && mem_wr == 1'b0, "R2 reset outputs",
              {cpu_ready, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        wb0 = wb_cnt;
        access(1'b0, 15'h805, 12'h000, rd, lat);
        check(lat > 1, "R2 line invalid after reset", lat, 2);
        check(rd == 12'h7FA, "R2 refill data", rd, 12'h7FA);
        check(wb_cnt == wb0, "R2 R7 no write-back after reset", wb_cnt - wb0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule